// File: doc/BRIEF.md
# Serial Blink-Code Fault Reporter

This block reports a 32-bit fault word on a single indicator LED. Each bit becomes one flash: a long flash stands for a one and a short flash for a zero. Flashes come in groups of four, one group per hexadecimal digit. The most significant digit is sent first, and within each group the most significant bit of the digit is sent first. A short dark gap separates flashes inside a group. A longer dark gap separates groups. A still longer pause closes each 32-flash frame, and the frame then repeats.

The reporter runs only while its enable is high. The surrounding logic raises enable once a failure has been recorded and leaves it low on a pass. The fault word is sampled at the first flash of every frame, so a word that changes during a frame appears only in the next frame. All on-times and off-times are parameters counted in clock cycles. The group gap must be longer than the flash gap. Dropping enable darkens the LED at the next clock edge and discards all progress.

Top module: `blink_code_reporter`

## Requirements
- R1: `led_o` is low in the cycle after any clock edge at which `rst_n` is low or `enable_i` is low.
- R2: A frame is 32 flashes carrying `code_i[31]` first and `code_i[0]` last, so hexadecimal digits go most significant first and each digit goes from its bit 3 down to its bit 0.
- R3: A flash for a one lasts exactly `LONG_ON` cycles, and a flash for a zero lasts exactly `SHORT_ON` cycles.
- R4: Between two flashes of the same digit, the LED is dark for exactly `FLASH_GAP` cycles.
- R5: Between the last flash of one digit and the first flash of the next digit, the LED is dark for exactly `GROUP_GAP` cycles.
- R6: After the 32nd flash, the LED is dark for exactly `FRAME_GAP` cycles, and then the next frame begins while enable stays high.
- R7: `code_i` is sampled only at the clock edge that starts a frame. Changes during a frame have no effect until the next frame.
- R8: After enable goes low and then high again, reporting restarts from bit 31 of a freshly sampled code.
- R9: At a clock edge where enable is high after having been low, the first flash begins at once, so `led_o` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | High while a failure is to be reported |
| code_i | input | CODE_W | Fault word, sampled at each frame start |
| led_o | output | 1 | LED drive, high while a flash is lit |

## Verification
The hardest case to reach from the ports is a change of the fault word, or a drop of enable, at an arbitrary point deep inside a frame: inside a lit flash, inside a group gap, or inside the closing pause. The bench reaches these cases by changing `code_i` and pulsing `enable_i` low at cycle offsets that do not line up with frame boundaries. A queue-based reference model predicts the LED level for every cycle. A width decoder rebuilds each received frame and compares it with the word that was sampled when that frame began.

// File: rtl/blink_pkg.sv
// Package for the blink-code reporter.
// Holds the controller phase encoding and the kind of dark gap that follows a flash.
package blink_pkg;

    // Controller phase: waiting for enable, LED lit, dark gap, end-of-frame pause
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LIT   = 2'd1,
        PH_DARK  = 2'd2,
        PH_PAUSE = 2'd3
    } blink_phase_e;

    // Which dark interval follows the flash that just ended
    typedef enum logic [1:0] {
        GAP_IN_DIGIT  = 2'd0,
        GAP_DIGIT_END = 2'd1,
        GAP_FRAME_END = 2'd2
    } blink_gap_e;

endpackage

// File: rtl/blink_timer.sv
// Down-counting interval timer.
// Does: holds a loaded count and decrements it to zero. done is high while the count is zero.
// Assumes: load has priority over decrement, and clr has priority over both.
module blink_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: clear, load, or step down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag
    assign done = (cnt_q == '0);

endmodule

// File: rtl/blink_bit_seq.sv
// Bit sequencer for the blink-code reporter.
// Does: holds the sampled fault word in a left-shifting register and tracks the bit index
//       and the position inside the current digit.
// Assumes: DIGIT_W >= 2 and CODE_W is a whole multiple of DIGIT_W. load takes code_i whole,
//          and advance moves to the next lower bit.
module blink_bit_seq #(
    parameter int CODE_W  = 32,
    parameter int DIGIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              advance,
    input  logic [CODE_W-1:0] code_i,
    output logic              next_bit,
    output logic              last_bit,
    output logic              digit_end
);

    localparam int IDX_W = $clog2(CODE_W);
    localparam int POS_W = $clog2(DIGIT_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_W - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(DIGIT_W - 1);

    logic [CODE_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic [POS_W-1:0]  pos_q;

    // Word register: sample the whole code, or shift left by one bit per flash
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shift_q <= '0;
        end else if (load) begin
            shift_q <= code_i;
        end else if (advance) begin
            shift_q <= {shift_q[CODE_W-2:0], 1'b0};
        end
    end

    // Bit index within the frame
    always_ff @(posedge clk) begin
        if (!rst_n || clr || load) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Position within the current digit, wrapping at the digit width
    always_ff @(posedge clk) begin
        if (!rst_n || clr || load) begin
            pos_q <= '0;
        end else if (advance) begin
            pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        end
    end

    // Bit to be sent once the next advance has taken effect
    assign next_bit  = shift_q[CODE_W-2];
    assign last_bit  = (idx_q == IDX_LAST);
    assign digit_end = (pos_q == POS_LAST);

endmodule

// File: rtl/blink_ctrl.sv
// Phase controller for the blink-code reporter.
// Does: steps through lit, dark and pause phases and picks each interval length.
//       Interval lengths are loaded into the timer as length minus one.
// Assumes: every duration is at least 1 and fits in CNT_W bits. A low enable forces idle at once.
module blink_ctrl
    import blink_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SHORT_ON  = 2,
    parameter int LONG_ON   = 5,
    parameter int FLASH_GAP = 2,
    parameter int GROUP_GAP = 4,
    parameter int FRAME_GAP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             first_bit,
    input  logic             next_bit,
    input  logic             last_bit,
    input  logic             digit_end,
    input  logic             tmr_done,
    output blink_phase_e     phase,
    output logic             tmr_clr,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             seq_clr,
    output logic             seq_load,
    output logic             seq_adv
);

    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_ON - 1);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(LONG_ON - 1);
    localparam logic [CNT_W-1:0] LEN_FLASH = CNT_W'(FLASH_GAP - 1);
    localparam logic [CNT_W-1:0] LEN_GROUP = CNT_W'(GROUP_GAP - 1);
    localparam logic [CNT_W-1:0] LEN_FRAME = CNT_W'(FRAME_GAP - 1);

    blink_phase_e phase_q;
    blink_gap_e   gap_kind;

    // Kind of gap that follows the flash now lit
    always_comb begin
        if (last_bit) begin
            gap_kind = GAP_FRAME_END;
        end else if (digit_end) begin
            gap_kind = GAP_DIGIT_END;
        end else begin
            gap_kind = GAP_IN_DIGIT;
        end
    end

    // Phase register: advance on timer expiry, drop to idle whenever enable is low
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:  phase_q <= PH_LIT;
                PH_LIT:   if (tmr_done) phase_q <= last_bit ? PH_PAUSE : PH_DARK;
                PH_DARK:  if (tmr_done) phase_q <= PH_LIT;
                PH_PAUSE: if (tmr_done) phase_q <= PH_LIT;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // Timer and sequencer commands for the current phase
    always_comb begin
        tmr_clr  = !enable_i;
        seq_clr  = !enable_i;
        tmr_load = 1'b0;
        tmr_val  = '0;
        seq_load = 1'b0;
        seq_adv  = 1'b0;
        if (enable_i) begin
            case (phase_q)
                PH_IDLE: begin
                    seq_load = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = first_bit ? LEN_LONG : LEN_SHORT;
                end
                PH_LIT: begin
                    if (tmr_done) begin
                        tmr_load = 1'b1;
                        case (gap_kind)
                            GAP_FRAME_END: tmr_val = LEN_FRAME;
                            GAP_DIGIT_END: tmr_val = LEN_GROUP;
                            default:       tmr_val = LEN_FLASH;
                        endcase
                    end
                end
                PH_DARK: begin
                    if (tmr_done) begin
                        seq_adv  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = next_bit ? LEN_LONG : LEN_SHORT;
                    end
                end
                PH_PAUSE: begin
                    if (tmr_done) begin
                        seq_load = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = first_bit ? LEN_LONG : LEN_SHORT;
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/blink_code_reporter.sv
// Blink-code fault reporter, top level.
// Does: sends CODE_W bits as long and short flashes on one LED, most significant bit first,
//       grouped by DIGIT_W bits. Each frame repeats while enable is high.
// Assumes: all durations are at least 1, GROUP_GAP > FLASH_GAP and LONG_ON > SHORT_ON.
//          code_i is sampled only at frame start.
module blink_code_reporter
    import blink_pkg::*;
#(
    parameter int CODE_W    = 32,
    parameter int DIGIT_W   = 4,
    parameter int SHORT_ON  = 2_500_000,
    parameter int LONG_ON   = 7_500_000,
    parameter int FLASH_GAP = 2_500_000,
    parameter int GROUP_GAP = 10_000_000,
    parameter int FRAME_GAP = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              led_o
);

    localparam int MAX_ON  = (LONG_ON > SHORT_ON) ? LONG_ON : SHORT_ON;
    localparam int MAX_GAP = (FRAME_GAP > GROUP_GAP) ?
                             ((FRAME_GAP > FLASH_GAP) ? FRAME_GAP : FLASH_GAP) :
                             ((GROUP_GAP > FLASH_GAP) ? GROUP_GAP : FLASH_GAP);
    localparam int MAX_LEN = (MAX_ON > MAX_GAP) ? MAX_ON : MAX_GAP;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    blink_phase_e     phase;
    logic             tmr_clr, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             seq_clr, seq_load, seq_adv;
    logic             next_bit, last_bit, digit_end;

    blink_ctrl #(
        .CNT_W    (CNT_W),
        .SHORT_ON (SHORT_ON),
        .LONG_ON  (LONG_ON),
        .FLASH_GAP(FLASH_GAP),
        .GROUP_GAP(GROUP_GAP),
        .FRAME_GAP(FRAME_GAP)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .first_bit(code_i[CODE_W-1]),
        .next_bit (next_bit),
        .last_bit (last_bit),
        .digit_end(digit_end),
        .tmr_done (tmr_done),
        .phase    (phase),
        .tmr_clr  (tmr_clr),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .seq_clr  (seq_clr),
        .seq_load (seq_load),
        .seq_adv  (seq_adv)
    );

    blink_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    blink_bit_seq #(
        .CODE_W (CODE_W),
        .DIGIT_W(DIGIT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (seq_clr),
        .load     (seq_load),
        .advance  (seq_adv),
        .code_i   (code_i),
        .next_bit (next_bit),
        .last_bit (last_bit),
        .digit_end(digit_end)
    );

    // LED drive: lit exactly while the controller is in its lit phase
    assign led_o = (phase == PH_LIT);

endmodule

// File: rtl/blink_code_reporter_chk.sv
// Checker for the blink-code reporter, bound to the top module.
// Does: measures lit and dark run lengths at the LED pin and counts flashes per frame and per digit.
//       It then checks each interval against the parameters.
// Assumes: it sees the same clock, reset and ports as the top module.
module blink_code_reporter_chk #(
    parameter int CODE_W    = 32,
    parameter int DIGIT_W   = 4,
    parameter int SHORT_ON  = 2,
    parameter int LONG_ON   = 5,
    parameter int FLASH_GAP = 2,
    parameter int GROUP_GAP = 4,
    parameter int FRAME_GAP = 8
) (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic led_o
);

    logic        led_q, en_q, seen_q;
    logic [31:0] hi_run, lo_run;
    int unsigned flash_n, dig_n;
    logic        fall, rise;

    assign fall = led_q && !led_o && en_q;
    assign rise = !led_q && led_o && en_q;

    // Run-length and flash counters observed at the pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q   <= 1'b0;
            en_q    <= 1'b0;
            seen_q  <= 1'b0;
            hi_run  <= '0;
            lo_run  <= '0;
            flash_n <= 0;
            dig_n   <= 0;
        end else begin
            led_q  <= led_o;
            en_q   <= enable_i;
            seen_q <= enable_i ? (seen_q | led_o) : 1'b0;
            hi_run <= led_o ? hi_run + 1 : '0;
            lo_run <= led_o ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1);
            if (!enable_i) begin
                flash_n <= 0;
                dig_n   <= 0;
            end else if (fall) begin
                flash_n <= (flash_n == CODE_W - 1) ? 0 : flash_n + 1;
                dig_n   <= (dig_n == DIGIT_W - 1) ? 0 : dig_n + 1;
            end
        end
    end

    p_dark_in_reset_r1: assert property (@(posedge clk) !rst_n |=> !led_o);

    p_dark_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !led_o);

    p_flash_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (hi_run == SHORT_ON || hi_run == LONG_ON));

    p_flash_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_q && flash_n != 0 && dig_n != 0) |-> (lo_run == FLASH_GAP));

    p_group_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_q && flash_n != 0 && dig_n == 0) |-> (lo_run == GROUP_GAP));

    p_frame_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && seen_q && flash_n == 0) |-> (lo_run == FRAME_GAP));

    p_prompt_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !en_q) |=> led_o);

endmodule

bind blink_code_reporter blink_code_reporter_chk #(
    .CODE_W   (CODE_W),
    .DIGIT_W  (DIGIT_W),
    .SHORT_ON (SHORT_ON),
    .LONG_ON  (LONG_ON),
    .FLASH_GAP(FLASH_GAP),
    .GROUP_GAP(GROUP_GAP),
    .FRAME_GAP(FRAME_GAP)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable_i(enable_i),
    .led_o   (led_o)
);

// File: tb/sim_blink_code_reporter.sv
`timescale 1ns/1ps
module sim_blink_code_reporter;

    localparam int CW = 32;
    localparam int S  = 2;
    localparam int L  = 5;
    localparam int FG = 2;
    localparam int GG = 4;
    localparam int PG = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable_i = 1'b0;
    logic [CW-1:0] code_i = '0;
    logic          led_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    blink_code_reporter #(
        .CODE_W(CW), .DIGIT_W(4), .SHORT_ON(S), .LONG_ON(L),
        .FLASH_GAP(FG), .GROUP_GAP(GG), .FRAME_GAP(PG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .code_i(code_i), .led_o(led_o)
    );

    // Reference model: queue of expected LED levels with the requirement each one tests
    bit            q_v[$];
    string         q_t[$];
    bit            m_exp = 0;
    string         m_tag = "R1";
    bit            m_idle = 1;
    bit            m_fresh = 1;
    logic [CW-1:0] m_code = '0;

    task automatic push_run(input bit v, input int n, input string t);
        for (int k = 0; k < n; k++) begin
            q_v.push_back(v);
            q_t.push_back(t);
        end
    endtask

    task automatic build_frame(input logic [CW-1:0] c);
        m_code = c;
        for (int i = 0; i < CW; i++) begin
            bit b = c[CW-1-i];
            int n = b ? L : S;
            if (i == 0 && m_fresh) begin
                push_run(1'b1, 1, "R9");
                push_run(1'b1, n - 1, "R3");
            end else begin
                push_run(1'b1, n, "R3");
            end
            if (i == CW - 1)     push_run(1'b0, PG, "R6");
            else if (i % 4 == 3) push_run(1'b0, GG, "R5");
            else                 push_run(1'b0, FG, "R4");
        end
        m_fresh = 0;
    endtask

    // Model step at each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n || !enable_i) begin
            q_v.delete();
            q_t.delete();
            m_exp   = 1'b0;
            m_tag   = "R1";
            m_idle  = 1;
            m_fresh = 1;
        end else begin
            m_idle = 0;
            if (q_v.size() == 0) build_frame(code_i);
            m_exp = q_v.pop_front();
            m_tag = q_t.pop_front();
        end
    end

    // Comparison and width decoding, away from the active edge
    int            hi = 0;
    int            nb = 0;
    logic [CW-1:0] word = '0;
    always @(negedge clk) begin
        if (!finished) begin
            n_chk++;
            if (led_o !== m_exp) begin
                n_bad++;
                $display("FAIL %s cycle %0d: led_o=%b expected %b", m_tag, cyc, led_o, m_exp);
            end
            if (m_idle) begin
                hi = 0; nb = 0; word = '0;
            end else if (led_o) begin
                hi++;
            end else if (hi > 0) begin
                word = {word[CW-2:0], (hi >= L)};
                nb++;
                hi = 0;
                if (nb == CW) begin
                    n_chk++;
                    if (word !== m_code) begin
                        n_bad++;
                        $display("FAIL R2/R7/R8 decoded frame: got %h expected %h", word, m_code);
                    end
                    nb = 0;
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 200000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, cycles=%0d expected <= 200000", cyc);
            finish_run();
        end
    end

    // Stimulus
    initial begin
        // R1: enable and code active while in reset, LED must stay dark
        enable_i = 1'b1;
        code_i   = 32'h0000_0219;
        wait_cyc(5);
        enable_i = 1'b0;
        rst_n    = 1'b1;
        wait_cyc(20);
        // R2 R3 R4 R5 R6 R9: two whole frames of a mixed word
        enable_i = 1'b1;
        wait_cyc(480);
        // R7: change the word part-way through a frame
        code_i = 32'hFFFF_FFFF;
        wait_cyc(300);
        code_i = 32'h0000_0000;
        wait_cyc(260);
        code_i = 32'h8000_0001;
        wait_cyc(333);
        code_i = 32'hA5C3_0F96;
        wait_cyc(410);
        // R8: abort inside a lit flash and restart with a new word
        while (led_o !== 1'b1) @(negedge clk);
        enable_i = 1'b0;
        code_i   = 32'h1234_5678;
        wait_cyc(3);
        enable_i = 1'b1;
        wait_cyc(137);
        // R8: single-cycle enable drop during a gap
        while (led_o !== 1'b0) @(negedge clk);
        enable_i = 1'b0;
        code_i   = 32'hDEAD_BEEF;
        wait_cyc(1);
        enable_i = 1'b1;
        wait_cyc(500);
        // R1: disable while running, stays dark
        enable_i = 1'b0;
        wait_cyc(30);
        finish_run();
    end

endmodule